// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block is the program-counter unit of a small microcontroller core. It holds an 11-bit program counter and an 8-entry return-address stack, and it forms jump and call targets by combining a 9-bit address field from the current instruction with two page-select bits supplied from the status register. On each clock cycle it picks one of five ways to advance: step by one, step by two when the previous test instruction asks to skip, jump, call or return.

The instruction decoder drives one-cycle strobes for jump, call, return and skip, together with the address field and the page bits. The unit drives the current PC and the number of live stack entries. All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake and no back-pressure. Each strobe is sampled on every rising clock edge. When more than one strobe is high in the same cycle, a fixed priority picks the strobe that acts.

Top module: `pcu_top`

## Requirements
- R1: While reset is asserted (active low), the PC reads 0x7FF and the stack depth reads 0.
- R2: With no strobe active, the PC advances by one each cycle and wraps from 0x7FF to 0x000.
- R3: A skip strobe alone advances the PC by two, modulo 2^11 (0x7FE goes to 0x000, 0x7FF goes to 0x001).
- R4: A jump loads PC[10:9] from the page bits and PC[8:0] from the 9-bit address field.
- R5: A call loads PC[10:9] from the page bits, clears PC[8] and loads PC[7:0] from address-field bits 7:0. It pushes the address of the call plus one.
- R6: A return loads the PC from the most recently pushed entry that has not yet been popped, so nested calls unwind in reverse order.
- R7: The stack-depth output goes up by one on each call and down by one on each effective return. It saturates at 8.
- R8: A call made with 8 entries already live overwrites the oldest entry. The next 8 returns then deliver the 8 newest return addresses, newest first.
- R9: When strobes collide, the priority is return (only when the stack is non-empty), then call, then jump, then skip. The strobes that lose have no effect on the PC or on the stack.
- R10: A return strobe with an empty stack is ignored. Depth stays 0 and the PC follows the next strobe in priority, or advances by one if no other strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tgt_field | input | 9 | Address field taken from the instruction |
| page_sel | input | 2 | Page-select bits from the status register |
| jmp_req | input | 1 | Jump strobe |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe |
| skip_req | input | 1 | Skip request from a test instruction that produced zero |
| pc | output | 11 | Current program counter |
| stack_depth | output | 4 | Number of live return-stack entries (0 to 8) |

## Verification
Call and return can fall in the same cycle. The bench provokes this by raising both strobes together: once with a live stack, where the pop must win and no push may occur, and once with an empty stack, where the call must take effect. Skip and jump are also raised together, and the jump target must win. A reference model in the bench resolves priority directly from R9 and R10. Each scoreboard entry holds the PC and depth expected after that cycle, and later returns show whether a losing call left anything on the stack.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_SKIP = 3'd1,
    SEL_JMP  = 3'd2,
    SEL_CALL = 3'd3,
    SEL_RET  = 3'd4
  } pc_sel_e;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic    jmp_req,
  input  logic    call_req,
  input  logic    ret_req,
  input  logic    skip_req,
  input  logic    stk_empty,
  output pc_sel_e sel,
  output logic    push,
  output logic    pop
);

  // Return wins only when something can be popped; then call, jump, skip.
  always_comb begin
    sel = SEL_INC;
    if (ret_req && !stk_empty) sel = SEL_RET;
    else if (call_req)         sel = SEL_CALL;
    else if (jmp_req)          sel = SEL_JMP;
    else if (skip_req)         sel = SEL_SKIP;
  end

  assign push = (sel == SEL_CALL);
  assign pop  = (sel == SEL_RET);

endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int FIELD_W = 9,
  parameter int PAGE_W  = 2,
  localparam int PC_W   = FIELD_W + PAGE_W
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [PAGE_W-1:0]  page,
  output logic [PC_W-1:0]    jmp_tgt,
  output logic [PC_W-1:0]    call_tgt
);

  // Jump: full field below the page bits.
  assign jmp_tgt  = {page, field};
  // Call: top bit of the field is forced low, so entries sit in the lower half of a page.
  assign call_tgt = {page, 1'b0, field[FIELD_W-2:0]};

endmodule

// File: rtl/pcu_stack.sv
module pcu_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 11,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [AW-1:0]    push_data,
  output logic [AW-1:0]    top_data,
  output logic [CNT_W-1:0] depth,
  output logic             empty
);

  logic [AW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [PTR_W-1:0] wp_inc;
  logic [PTR_W-1:0] wp_dec;

  // Circular pointer: overflow silently overwrites the oldest slot.
  assign wp_inc   = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
  assign wp_dec   = (wp == '0) ? PTR_W'(DEPTH - 1) : wp - 1'b1;
  assign top_data = mem[wp_dec];
  assign empty    = (depth == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[wp] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      depth <= '0;
    end else if (push) begin
      wp <= wp_inc;
      if (depth != CNT_W'(DEPTH)) depth <= depth + 1'b1;
    end else if (pop) begin
      wp    <= wp_dec;
      depth <= depth - 1'b1;
    end
  end

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int FIELD_W = 9,
  parameter int PAGE_W  = 2,
  parameter int DEPTH   = 8,
  localparam int PC_W   = FIELD_W + PAGE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] tgt_field,
  input  logic [PAGE_W-1:0]  page_sel,
  input  logic               jmp_req,
  input  logic               call_req,
  input  logic               ret_req,
  input  logic               skip_req,
  output logic [PC_W-1:0]    pc,
  output logic [CNT_W-1:0]   stack_depth
);

  pc_sel_e         sel;
  logic            push, pop, stk_empty;
  logic [PC_W-1:0] jmp_tgt, call_tgt, ret_addr, pc_nx;

  pcu_ctrl u_ctrl (
    .jmp_req  (jmp_req),
    .call_req (call_req),
    .ret_req  (ret_req),
    .skip_req (skip_req),
    .stk_empty(stk_empty),
    .sel      (sel),
    .push     (push),
    .pop      (pop)
  );

  pcu_target #(.FIELD_W(FIELD_W), .PAGE_W(PAGE_W)) u_target (
    .field   (tgt_field),
    .page    (page_sel),
    .jmp_tgt (jmp_tgt),
    .call_tgt(call_tgt)
  );

  pcu_stack #(.DEPTH(DEPTH), .AW(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (pop),
    .push_data(pc + PC_W'(1)),
    .top_data (ret_addr),
    .depth    (stack_depth),
    .empty    (stk_empty)
  );

  always_comb begin
    unique case (sel)
      SEL_RET:  pc_nx = ret_addr;
      SEL_CALL: pc_nx = call_tgt;
      SEL_JMP:  pc_nx = jmp_tgt;
      SEL_SKIP: pc_nx = pc + PC_W'(2);
      default:  pc_nx = pc + PC_W'(1);
    endcase
  end

  // Reset vector is the last word of program space.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '1;
    else        pc <= pc_nx;
  end

endmodule

// File: rtl/pcu_top_chk.sv
module pcu_top_chk #(
  parameter int FIELD_W = 9,
  parameter int PAGE_W  = 2,
  parameter int DEPTH   = 8,
  localparam int PC_W   = FIELD_W + PAGE_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [FIELD_W-1:0] tgt_field,
  input logic [PAGE_W-1:0]  page_sel,
  input logic               jmp_req,
  input logic               call_req,
  input logic               ret_req,
  input logic               skip_req,
  input logic [PC_W-1:0]    pc,
  input logic [CNT_W-1:0]   stack_depth
);

  logic live_ret;
  assign live_ret = ret_req && (stack_depth != '0);

  // R2
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!jmp_req && !call_req && !ret_req && !skip_req) |=> pc == $past(pc) + PC_W'(1));

  // R3
  p_skip_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_req && !jmp_req && !call_req && !ret_req) |=> pc == $past(pc) + PC_W'(2));

  // R4
  p_jump_tgt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_req && !call_req && !live_ret) |=> pc == {$past(page_sel), $past(tgt_field)});

  // R5
  p_call_tgt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !live_ret) |=>
      pc == {$past(page_sel), 1'b0, $past(tgt_field[FIELD_W-2:0])});

  // R7
  p_depth_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !live_ret && stack_depth != CNT_W'(DEPTH)) |=>
      stack_depth == $past(stack_depth) + CNT_W'(1));

  // R7
  p_depth_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= CNT_W'(DEPTH));

  // R9
  p_ret_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    live_ret |=> stack_depth == $past(stack_depth) - CNT_W'(1));

  // R10
  p_empty_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && stack_depth == '0 && !call_req && !jmp_req && !skip_req) |=>
      (stack_depth == '0 && pc == $past(pc) + PC_W'(1)));

endmodule

bind pcu_top pcu_top_chk #(.FIELD_W(FIELD_W), .PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tgt_field  (tgt_field),
  .page_sel   (page_sel),
  .jmp_req    (jmp_req),
  .call_req   (call_req),
  .ret_req    (ret_req),
  .skip_req   (skip_req),
  .pc         (pc),
  .stack_depth(stack_depth)
);

// File: tb/pcu_top_tb_top.sv
`timescale 1ns/1ps
module pcu_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  tgt_field = '0;
  logic [1:0]  page_sel = '0;
  logic        jmp_req = 1'b0, call_req = 1'b0, ret_req = 1'b0, skip_req = 1'b0;
  logic [10:0] pc;
  logic [3:0]  stack_depth;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [10:0] pc;
    logic [3:0]  dep;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  exp_t        cur;
  logic [10:0] pc_m = 11'h7FF;
  logic [10:0] stk_m[$];

  always #2 clk = ~clk;

  pcu_top dut_i (
    .clk(clk), .rst_n(rst_n), .tgt_field(tgt_field), .page_sel(page_sel),
    .jmp_req(jmp_req), .call_req(call_req), .ret_req(ret_req), .skip_req(skip_req),
    .pc(pc), .stack_depth(stack_depth)
  );

  // Driver: apply one cycle of strobes and queue the outcome the requirements predict.
  task automatic step(input bit j, input bit c, input bit r, input bit s,
                      input logic [8:0] f, input logic [1:0] pg, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b1;
    jmp_req = j; call_req = c; ret_req = r; skip_req = s;
    tgt_field = f; page_sel = pg;
    if (r && stk_m.size() > 0) begin
      pc_m = stk_m.pop_back();
    end else if (c) begin
      if (stk_m.size() == 8) void'(stk_m.pop_front());
      stk_m.push_back(pc_m + 11'd1);
      pc_m = {pg, 1'b0, f[7:0]};
    end else if (j) begin
      pc_m = {pg, f};
    end else if (s) begin
      pc_m = pc_m + 11'd2;
    end else begin
      pc_m = pc_m + 11'd1;
    end
    e.pc = pc_m;
    e.dep = 4'(stk_m.size());
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: one scoreboard entry per clock edge, sampled after the edge settles.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      cur = sb.pop_front();
      checks++;
      if (pc !== cur.pc || stack_depth !== cur.dep) begin
        errors++;
        $display("FAIL %s: pc=%h depth=%0d expected pc=%h depth=%0d",
                 cur.tag, pc, stack_depth, cur.pc, cur.dep);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pc !== 11'h7FF || stack_depth !== 4'd0) begin
      errors++;
      $display("FAIL R1: pc=%h depth=%0d expected pc=7ff depth=0", pc, stack_depth);
    end
    // R2: the first step wraps 7FF to 000.
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 9'h000, 2'd0, "R2");
    // R3: skip, then skip across the top of memory.
    step(0, 0, 0, 1, 9'h000, 2'd0, "R3");
    step(1, 0, 0, 0, 9'h1FE, 2'd3, "R4");
    step(0, 0, 0, 1, 9'h000, 2'd0, "R3");
    step(1, 0, 0, 0, 9'h1FF, 2'd3, "R4");
    step(0, 0, 0, 1, 9'h000, 2'd0, "R3");
    // R4: jumps into several pages.
    step(1, 0, 0, 0, 9'h155, 2'd1, "R4");
    step(1, 0, 0, 0, 9'h0AA, 2'd2, "R4");
    // R9: skip and jump together; the jump wins.
    step(1, 0, 0, 1, 9'h033, 2'd0, "R9");
    step(0, 0, 0, 0, 9'h000, 2'd0, "R2");
    // R10: return on an empty stack does nothing.
    step(0, 0, 1, 0, 9'h000, 2'd0, "R10");
    // R5: a call clears field bit 8; nested calls R6.
    step(0, 1, 0, 0, 9'h1AB, 2'd2, "R5");
    step(0, 0, 0, 0, 9'h000, 2'd0, "R2");
    step(0, 1, 0, 0, 9'h010, 2'd1, "R5");
    step(0, 1, 0, 0, 9'h120, 2'd3, "R5");
    // R9: call and return together with a live stack; the return wins.
    step(0, 1, 1, 0, 9'h0FF, 2'd0, "R9");
    step(0, 0, 1, 0, 9'h000, 2'd0, "R6");
    step(0, 0, 1, 0, 9'h000, 2'd0, "R6");
    // R9: call and return together with an empty stack; the call acts.
    step(0, 1, 1, 0, 9'h044, 2'd1, "R9");
    step(0, 0, 1, 0, 9'h000, 2'd0, "R6");
    // R7 and R8: nine calls saturate depth and drop the oldest.
    for (int i = 0; i < 9; i++) step(0, 1, 0, 0, 9'(i * 16 + 3), 2'(i), "R7");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 9'h000, 2'd0, "R8");
    step(0, 0, 1, 0, 9'h000, 2'd0, "R10");
    step(0, 0, 0, 0, 9'h000, 2'd0, "R2");
    @(negedge clk);
    jmp_req = 0; call_req = 0; ret_req = 0; skip_req = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule